// File: doc/BRIEF.md
# Register Write Combining Shim

This shim sits on the register path between a processor-side bus and a host controller register file. Some of that register file's registers accept only full 32-bit writes. A 16-bit write to the transfer-mode register is held back in a local shadow register. When the 16-bit command write that follows it arrives, the shim turns the pair into one 32-bit write, so the controller sees both halves in a single atomic update.

The shim also changes two 32-bit writes on their way through. Writes to the interrupt signal-enable register lose their timeout and CRC error bits. When gap detection is switched on, a write to the interrupt status-enable register is followed by a read-modify-write of the block-gap control byte. A second option lets a 16-bit read of the host version register be answered locally with a fixed code. All other traffic passes through unchanged.

Both request channels use valid/ready. A request that is offered must hold its payload until it is accepted. The upstream `up_ready` stays low while a read response is outstanding and while the gap read-modify-write is running. Read data returns on a separate response strobe, one response per accepted read. Data is right-aligned: a byte or halfword value sits in the low bits of the data bus.

Top module: `regwr_combine_shim`

## Requirements
- R1: A halfword (size code 1) write to the transfer-mode offset (0x0C) is accepted at once, updates the shadow register and produces no downstream request.
- R2: A halfword write to the command offset (0x0E) produces exactly one downstream word (size code 2) write to 0x0C, with data {command[15:0], shadow[15:0]}. The downstream side never sees a halfword write to 0x0E.
- R3: After reset, no valid or response strobe is active and the shadow register holds zero. A command write that has no transfer-mode write before it uses the current shadow value, and the shadow value is kept across several command writes.
- R4: Writes of any other offset or size (byte code 0, halfword, word) are forwarded with their address, size and data unchanged.
- R5: A word write to the signal-enable offset (0x38) is forwarded with bits 16 (timeout) and 17 (CRC) forced to zero and all other bits unchanged.
- R6: With `gap_det_en` high, a word write to the status-enable offset (0x34) is forwarded unchanged. In the very next cycle the shim requests a byte read of 0x2A. It then writes that byte back to 0x2A with bit 3 equal to bit 8 (card interrupt) of the original write data and every other bit preserved.
- R7: With `gap_det_en` low, a write to 0x34 is only forwarded, with no follow-up traffic.
- R8: With `ver_ovr_en` high, a halfword read of 0x0FE is answered one cycle after acceptance with data 0x0001 and no downstream request. With the option low, or for other sizes, the read is forwarded.
- R9: While a downstream request waits for `dn_ready`, the request stays valid with stable address, direction and data. No new upstream request is accepted while a response is owed or the gap sequence runs.
- R10: A forwarded read returns the downstream read data unmodified on `up_rdata` with `up_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gap_det_en | input | 1 | Enables the gap-control follow-up after status-enable writes |
| ver_ovr_en | input | 1 | Enables the local answer for version reads |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request accepted |
| up_write | input | 1 | 1 = write, 0 = read |
| up_size | input | 2 | 0 byte, 1 halfword, 2 word |
| up_addr | input | ADDR_W | Register byte offset |
| up_wdata | input | DATA_W | Right-aligned write data |
| up_rvalid | output | 1 | Read response strobe |
| up_rdata | output | DATA_W | Read response data |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request accepted |
| dn_write | output | 1 | 1 = write, 0 = read |
| dn_size | output | 2 | 0 byte, 1 halfword, 2 word |
| dn_addr | output | ADDR_W | Register byte offset |
| dn_wdata | output | DATA_W | Right-aligned write data |
| dn_rvalid | input | 1 | Downstream read response strobe |
| dn_rdata | input | DATA_W | Downstream read response data |

## Verification
Some rules are checked by the assertions on every cycle. These are: the downstream side never sees a halfword command write or a signal-enable word with error bits set; a transfer-mode write is absorbed without a downstream request; a status-enable write with gap detection on is followed at once by the gap byte read; a version read is answered locally in the next cycle; a stalled downstream request holds steady; and no request is taken while a response is owed. Only the bench scenarios can show the values that depend on history. These are the merged word carrying the most recent shadow value, the value of the written-back gap byte, the order of requests around the read-modify-write, and pass-through of read data under irregular back-pressure.

// File: rtl/shim_pkg.sv
package shim_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } xfer_size_e;

  typedef enum logic [2:0] {
    K_PASS,
    K_SHADOW,
    K_MERGE,
    K_MASK,
    K_INTEN,
    K_VER
  } req_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_WAIT,
    S_LOC_RSP,
    S_GAP_RD,
    S_GAP_WAIT,
    S_GAP_WR
  } seq_state_e;

endpackage

// File: rtl/shim_decode.sv
module shim_decode
  import shim_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] XFER_OFS  = 8'h0C,
  parameter logic [ADDR_W-1:0] CMD_OFS   = 8'h0E,
  parameter logic [ADDR_W-1:0] SIGEN_OFS = 8'h38,
  parameter logic [ADDR_W-1:0] INTEN_OFS = 8'h34,
  parameter logic [ADDR_W-1:0] VER_OFS   = 8'hFE
) (
  input  logic              is_write,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic              gap_en,
  input  logic              ver_en,
  output req_kind_e         kind
);

  logic half_op, word_op;

  assign half_op = (size == SZ_HALF);
  assign word_op = (size == SZ_WORD);

  always_comb begin
    kind = K_PASS;
    if (is_write) begin
      if (half_op && addr == XFER_OFS)                 kind = K_SHADOW;
      else if (half_op && addr == CMD_OFS)             kind = K_MERGE;
      else if (word_op && addr == SIGEN_OFS)           kind = K_MASK;
      else if (word_op && addr == INTEN_OFS && gap_en) kind = K_INTEN;
    end else if (half_op && addr == VER_OFS && ver_en) begin
      kind = K_VER;
    end
  end

endmodule

// File: rtl/shim_xform.sv
module shim_xform
  import shim_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] XFER_OFS  = 8'h0C,
  parameter logic [DATA_W-1:0] DROP_MASK = 32'h0003_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shadow_load,
  input  req_kind_e         kind,
  input  logic [1:0]        in_size,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic [1:0]        out_size,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);

  localparam int unsigned HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] shadow_q;

  // Held transfer-mode halfword, joined to the next command halfword.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           shadow_q <= '0;
    else if (shadow_load) shadow_q <= in_data[HALF_W-1:0];
  end

  always_comb begin
    out_size = in_size;
    out_addr = in_addr;
    out_data = in_data;
    case (kind)
      K_MERGE: begin
        out_size = SZ_WORD;
        out_addr = XFER_OFS;
        out_data = {in_data[HALF_W-1:0], shadow_q};
      end
      K_MASK:  out_data = in_data & ~DROP_MASK;
      default: ;
    endcase
  end

endmodule

// File: rtl/shim_seq.sv
module shim_seq
  import shim_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] GAP_OFS = 8'h2A,
  parameter int unsigned GAP_BIT = 3,
  parameter logic [DATA_W/2-1:0] VER_CODE = 16'h0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  req_kind_e         kind,
  input  logic              card_int,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic              up_write,
  output logic              up_rvalid,
  output logic [DATA_W-1:0] up_rdata,
  input  logic [1:0]        xf_size,
  input  logic [ADDR_W-1:0] xf_addr,
  input  logic [DATA_W-1:0] xf_data,
  output logic              shadow_load,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_write,
  output logic [1:0]        dn_size,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic              dn_rvalid,
  input  logic [DATA_W-1:0] dn_rdata
);

  localparam int unsigned HALF_W = DATA_W / 2;
  localparam logic [7:0]  GAP_MSK = 8'(1 << GAP_BIT);

  seq_state_e st_q, st_d;
  logic       card_q;
  logic [7:0] gap_q;
  logic [7:0] gap_new;

  assign gap_new = card_q ? (gap_q | GAP_MSK) : (gap_q & ~GAP_MSK);

  always_comb begin
    st_d        = st_q;
    up_ready    = 1'b0;
    up_rvalid   = 1'b0;
    up_rdata    = '0;
    shadow_load = 1'b0;
    dn_valid    = 1'b0;
    dn_write    = 1'b0;
    dn_size     = SZ_BYTE;
    dn_addr     = '0;
    dn_wdata    = '0;
    case (st_q)
      S_IDLE: begin
        case (kind)
          K_SHADOW: begin
            up_ready    = 1'b1;
            shadow_load = up_valid;
          end
          K_VER: begin
            up_ready = 1'b1;
            if (up_valid) st_d = S_LOC_RSP;
          end
          default: begin
            dn_valid = up_valid;
            dn_write = up_write;
            dn_size  = xf_size;
            dn_addr  = xf_addr;
            dn_wdata = xf_data;
            up_ready = dn_ready;
            if (up_valid && dn_ready) begin
              if (!up_write)            st_d = S_RD_WAIT;
              else if (kind == K_INTEN) st_d = S_GAP_RD;
            end
          end
        endcase
      end
      S_RD_WAIT: begin
        up_rvalid = dn_rvalid;
        up_rdata  = dn_rdata;
        if (dn_rvalid) st_d = S_IDLE;
      end
      S_LOC_RSP: begin
        up_rvalid = 1'b1;
        up_rdata  = {{HALF_W{1'b0}}, VER_CODE};
        st_d      = S_IDLE;
      end
      S_GAP_RD: begin
        dn_valid = 1'b1;
        dn_addr  = GAP_OFS;
        if (dn_ready) st_d = S_GAP_WAIT;
      end
      S_GAP_WAIT: begin
        if (dn_rvalid) st_d = S_GAP_WR;
      end
      S_GAP_WR: begin
        dn_valid = 1'b1;
        dn_write = 1'b1;
        dn_addr  = GAP_OFS;
        dn_wdata = {{(DATA_W-8){1'b0}}, gap_new};
        if (dn_ready) st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      card_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == S_IDLE && kind == K_INTEN && up_valid && dn_ready)
        card_q <= card_int;
      if (st_q == S_GAP_WAIT && dn_rvalid)
        gap_q <= dn_rdata[7:0];
    end
  end

endmodule

// File: rtl/regwr_combine_shim.sv
module regwr_combine_shim
  import shim_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] XFER_OFS  = 8'h0C,
  parameter logic [ADDR_W-1:0] CMD_OFS   = 8'h0E,
  parameter logic [ADDR_W-1:0] SIGEN_OFS = 8'h38,
  parameter logic [ADDR_W-1:0] INTEN_OFS = 8'h34,
  parameter logic [ADDR_W-1:0] GAP_OFS   = 8'h2A,
  parameter logic [ADDR_W-1:0] VER_OFS   = 8'hFE,
  parameter logic [DATA_W-1:0] DROP_MASK = 32'h0003_0000,
  parameter int unsigned CARD_BIT = 8,
  parameter int unsigned GAP_BIT  = 3,
  parameter logic [DATA_W/2-1:0] VER_CODE = 16'h0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gap_det_en,
  input  logic              ver_ovr_en,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic              up_write,
  input  logic [1:0]        up_size,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [DATA_W-1:0] up_wdata,
  output logic              up_rvalid,
  output logic [DATA_W-1:0] up_rdata,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_write,
  output logic [1:0]        dn_size,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic              dn_rvalid,
  input  logic [DATA_W-1:0] dn_rdata
);

  req_kind_e         kind;
  logic              shadow_load;
  logic [1:0]        xf_size;
  logic [ADDR_W-1:0] xf_addr;
  logic [DATA_W-1:0] xf_data;

  shim_decode #(
    .ADDR_W(ADDR_W), .XFER_OFS(XFER_OFS), .CMD_OFS(CMD_OFS),
    .SIGEN_OFS(SIGEN_OFS), .INTEN_OFS(INTEN_OFS), .VER_OFS(VER_OFS)
  ) u_decode (
    .is_write (up_write),
    .size     (up_size),
    .addr     (up_addr),
    .gap_en   (gap_det_en),
    .ver_en   (ver_ovr_en),
    .kind     (kind)
  );

  shim_xform #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .XFER_OFS(XFER_OFS), .DROP_MASK(DROP_MASK)
  ) u_xform (
    .clk         (clk),
    .rst_n       (rst_n),
    .shadow_load (shadow_load),
    .kind        (kind),
    .in_size     (up_size),
    .in_addr     (up_addr),
    .in_data     (up_wdata),
    .out_size    (xf_size),
    .out_addr    (xf_addr),
    .out_data    (xf_data)
  );

  shim_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAP_OFS(GAP_OFS),
    .GAP_BIT(GAP_BIT), .VER_CODE(VER_CODE)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .kind        (kind),
    .card_int    (up_wdata[CARD_BIT]),
    .up_valid    (up_valid),
    .up_ready    (up_ready),
    .up_write    (up_write),
    .up_rvalid   (up_rvalid),
    .up_rdata    (up_rdata),
    .xf_size     (xf_size),
    .xf_addr     (xf_addr),
    .xf_data     (xf_data),
    .shadow_load (shadow_load),
    .dn_valid    (dn_valid),
    .dn_ready    (dn_ready),
    .dn_write    (dn_write),
    .dn_size     (dn_size),
    .dn_addr     (dn_addr),
    .dn_wdata    (dn_wdata),
    .dn_rvalid   (dn_rvalid),
    .dn_rdata    (dn_rdata)
  );

endmodule

// File: rtl/shim_checks.sv
module shim_checks #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] XFER_OFS  = 8'h0C,
  parameter logic [ADDR_W-1:0] CMD_OFS   = 8'h0E,
  parameter logic [ADDR_W-1:0] SIGEN_OFS = 8'h38,
  parameter logic [ADDR_W-1:0] INTEN_OFS = 8'h34,
  parameter logic [ADDR_W-1:0] GAP_OFS   = 8'h2A,
  parameter logic [ADDR_W-1:0] VER_OFS   = 8'hFE,
  parameter logic [DATA_W-1:0] DROP_MASK = 32'h0003_0000,
  parameter logic [DATA_W/2-1:0] VER_CODE = 16'h0001
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gap_det_en,
  input logic              ver_ovr_en,
  input logic              up_valid,
  input logic              up_ready,
  input logic              up_write,
  input logic [1:0]        up_size,
  input logic [ADDR_W-1:0] up_addr,
  input logic              up_rvalid,
  input logic [DATA_W-1:0] up_rdata,
  input logic              dn_valid,
  input logic              dn_ready,
  input logic              dn_write,
  input logic [1:0]        dn_size,
  input logic [ADDR_W-1:0] dn_addr,
  input logic [DATA_W-1:0] dn_wdata
);

  logic up_hs;
  assign up_hs = up_valid && up_ready;

  assert_absorb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (up_hs && up_write && up_size == 2'd1 && up_addr == XFER_OFS) |-> !dn_valid);

  assert_no_half_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_write) |-> !(dn_size == 2'd1 && dn_addr == CMD_OFS));

  assert_err_bits_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_write && dn_size == 2'd2 && dn_addr == SIGEN_OFS)
      |-> ((dn_wdata & DROP_MASK) == '0));

  assert_gap_read_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (up_hs && up_write && up_size == 2'd2 && up_addr == INTEN_OFS && gap_det_en)
      |=> (dn_valid && !dn_write && dn_size == 2'd0 && dn_addr == GAP_OFS));

  assert_local_version_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (up_hs && !up_write && up_size == 2'd1 && up_addr == VER_OFS && ver_ovr_en)
      |=> (up_rvalid && up_rdata == {{(DATA_W/2){1'b0}}, VER_CODE}));

  assert_dn_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_write)
      && $stable(dn_size) && $stable(dn_wdata)));

  assert_no_accept_while_owed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    up_rvalid |-> !up_ready);

endmodule

bind regwr_combine_shim shim_checks #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .XFER_OFS(XFER_OFS), .CMD_OFS(CMD_OFS),
  .SIGEN_OFS(SIGEN_OFS), .INTEN_OFS(INTEN_OFS), .GAP_OFS(GAP_OFS),
  .VER_OFS(VER_OFS), .DROP_MASK(DROP_MASK), .VER_CODE(VER_CODE)
) u_checks (
  .clk(clk), .rst_n(rst_n), .gap_det_en(gap_det_en), .ver_ovr_en(ver_ovr_en),
  .up_valid(up_valid), .up_ready(up_ready), .up_write(up_write),
  .up_size(up_size), .up_addr(up_addr), .up_rvalid(up_rvalid),
  .up_rdata(up_rdata), .dn_valid(dn_valid), .dn_ready(dn_ready),
  .dn_write(dn_write), .dn_size(dn_size), .dn_addr(dn_addr),
  .dn_wdata(dn_wdata)
);

// File: tb/regwr_combine_shim_test.sv
`timescale 1ns/1ps
module regwr_combine_shim_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gap_det_en = 1'b0;
  logic        ver_ovr_en = 1'b0;
  logic        up_valid = 1'b0;
  logic        up_ready;
  logic        up_write = 1'b0;
  logic [1:0]  up_size = 2'd0;
  logic [7:0]  up_addr = 8'h00;
  logic [31:0] up_wdata = 32'h0;
  logic        up_rvalid;
  logic [31:0] up_rdata;
  logic        dn_valid;
  logic        dn_ready = 1'b0;
  logic        dn_write;
  logic [1:0]  dn_size;
  logic [7:0]  dn_addr;
  logic [31:0] dn_wdata;
  logic        dn_rvalid = 1'b0;
  logic [31:0] dn_rdata = 32'h0;

  int checks = 0;
  int fails  = 0;
  bit hold_dn = 1'b0;
  bit done = 1'b0;

  logic [42:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] rd_q[$];
  string       rtag_q[$];

  always #4 clk = ~clk;

  regwr_combine_shim uut (
    .clk(clk), .rst_n(rst_n), .gap_det_en(gap_det_en), .ver_ovr_en(ver_ovr_en),
    .up_valid(up_valid), .up_ready(up_ready), .up_write(up_write),
    .up_size(up_size), .up_addr(up_addr), .up_wdata(up_wdata),
    .up_rvalid(up_rvalid), .up_rdata(up_rdata),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write),
    .dn_size(dn_size), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_rvalid(dn_rvalid), .dn_rdata(dn_rdata)
  );

  function automatic logic [31:0] rd_model(logic [7:0] a);
    return {8'hC3, a, 8'h5A, a ^ 8'h55};
  endfunction

  function automatic void check(bit ok, string tag, logic [42:0] act, logic [42:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endfunction

  function automatic void expect_dn(bit w, logic [1:0] sz, logic [7:0] a,
                                    logic [31:0] d, string t);
    exp_q.push_back({w, sz, a, w ? d : 32'h0});
    tag_q.push_back(t);
  endfunction

  function automatic void expect_rd(logic [31:0] d, string t);
    rd_q.push_back(d);
    rtag_q.push_back(t);
  endfunction

  task automatic up_op(bit w, logic [1:0] sz, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    up_write = w; up_size = sz; up_addr = a; up_wdata = d; up_valid = 1'b1;
    forever begin
      #3;
      if (up_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  // Downstream responder and scoreboard monitor.
  initial begin
    bit          pend = 1'b0;
    logic [7:0]  paddr = 8'h0;
    int          cyc = 0;
    bit          was_stalled = 1'b0;
    logic [42:0] stall_item = '0;
    forever begin
      @(negedge clk);
      dn_rvalid = pend;
      dn_rdata  = pend ? rd_model(paddr) : 32'h0;
      pend      = 1'b0;
      dn_ready  = hold_dn ? 1'b0 : ((cyc % 3) != 2);
      cyc++;
      #3;
      if (rst_n) begin
        logic [42:0] got;
        got = {dn_write, dn_size, dn_addr, dn_write ? dn_wdata : 32'h0};
        if (was_stalled)
          check(dn_valid && got == stall_item, "R9 stalled request changed", got, stall_item);
        was_stalled = dn_valid && !dn_ready;
        stall_item  = got;
        if (dn_valid && dn_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R4 unexpected downstream request", got, '0);
          end else begin
            logic [42:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(got == e, t, got, e);
          end
          if (!dn_write) begin
            pend  = 1'b1;
            paddr = dn_addr;
          end
        end
        if (up_rvalid) begin
          if (rd_q.size() == 0) begin
            check(1'b0, "R10 unexpected read response", {11'h0, up_rdata}, '0);
          end else begin
            logic [31:0] e;
            string t;
            e = rd_q.pop_front();
            t = rtag_q.pop_front();
            check(up_rdata == e, t, {11'h0, up_rdata}, {11'h0, e});
          end
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R3: reset state
    check(!dn_valid && !up_rvalid, "R3 reset outputs idle", {41'h0, dn_valid, up_rvalid}, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3: command with no prior transfer-mode write uses zero shadow
    expect_dn(1, 2'd2, 8'h0C, 32'h0C1A_0000, "R3 merge with reset shadow");
    up_op(1, 2'd1, 8'h0E, 32'h0000_0C1A);

    // R1 and R2: absorbed transfer-mode write then merged command
    up_op(1, 2'd1, 8'h0C, 32'h0000_0023);
    expect_dn(1, 2'd2, 8'h0C, 32'h0C3A_0023, "R2 merged command word");
    up_op(1, 2'd1, 8'h0E, 32'h0000_0C3A);
    // R3: shadow retained for second command
    expect_dn(1, 2'd2, 8'h0C, 32'h1111_0023, "R3 shadow retained");
    up_op(1, 2'd1, 8'h0E, 32'h0000_1111);

    // R4: pass-through of other writes
    expect_dn(1, 2'd1, 8'h04, 32'h0000_BEEF, "R4 halfword pass");
    up_op(1, 2'd1, 8'h04, 32'h0000_BEEF);
    expect_dn(1, 2'd0, 8'h28, 32'h0000_0005, "R4 byte pass");
    up_op(1, 2'd0, 8'h28, 32'h0000_0005);
    expect_dn(1, 2'd2, 8'h08, 32'hDEAD_0123, "R4 word pass");
    up_op(1, 2'd2, 8'h08, 32'hDEAD_0123);
    expect_dn(1, 2'd2, 8'h34, 32'h0000_0100, "R7 status-enable without gap option");
    up_op(1, 2'd2, 8'h34, 32'h0000_0100);
    expect_dn(1, 2'd1, 8'h10, 32'h0000_0077, "R7 no follow-up traffic");
    up_op(1, 2'd1, 8'h10, 32'h0000_0077);

    // R5: error bits dropped on signal-enable
    expect_dn(1, 2'd2, 8'h38, 32'hFFFC_FFFF, "R5 mask all-ones");
    up_op(1, 2'd2, 8'h38, 32'hFFFF_FFFF);
    expect_dn(1, 2'd2, 8'h38, 32'h0000_0101, "R5 mask partial");
    up_op(1, 2'd2, 8'h38, 32'h0003_0101);

    // R6: gap read-modify-write, card bit set then cleared
    gap_det_en = 1'b1;
    expect_dn(1, 2'd2, 8'h34, 32'h0000_0100, "R6 status-enable forwarded");
    expect_dn(0, 2'd0, 8'h2A, 32'h0, "R6 gap byte read");
    expect_dn(1, 2'd0, 8'h2A, 32'h0000_007F, "R6 gap bit set");
    up_op(1, 2'd2, 8'h34, 32'h0000_0100);
    expect_dn(1, 2'd2, 8'h34, 32'h0000_00FF, "R6 status-enable forwarded");
    expect_dn(0, 2'd0, 8'h2A, 32'h0, "R6 gap byte read");
    expect_dn(1, 2'd0, 8'h2A, 32'h0000_0077, "R6 gap bit cleared");
    expect_dn(1, 2'd1, 8'h04, 32'h0000_4321, "R9 next request after sequence");
    up_op(1, 2'd2, 8'h34, 32'h0000_00FF);
    up_op(1, 2'd1, 8'h04, 32'h0000_4321);
    gap_det_en = 1'b0;

    // R8 and R10: version override and read pass-through
    ver_ovr_en = 1'b1;
    expect_rd(32'h0000_0001, "R8 local version code");
    up_op(0, 2'd1, 8'hFE, 32'h0);
    expect_dn(0, 2'd0, 8'hFE, 32'h0, "R8 byte version read forwarded");
    expect_rd(rd_model(8'hFE), "R10 byte read data");
    up_op(0, 2'd0, 8'hFE, 32'h0);
    ver_ovr_en = 1'b0;
    expect_dn(0, 2'd1, 8'hFE, 32'h0, "R8 version read forwarded when off");
    expect_rd(rd_model(8'hFE), "R8 forwarded version data");
    up_op(0, 2'd1, 8'hFE, 32'h0);
    expect_dn(0, 2'd2, 8'h40, 32'h0, "R10 word read forwarded");
    expect_rd(rd_model(8'h40), "R10 word read data");
    up_op(0, 2'd2, 8'h40, 32'h0);

    // R9: long downstream stall on a merged command
    expect_dn(1, 2'd2, 8'h0C, 32'h2222_0023, "R9 merged after stall");
    hold_dn = 1'b1;
    fork
      up_op(1, 2'd1, 8'h0E, 32'h0000_2222);
      begin
        repeat (6) @(negedge clk);
        hold_dn = 1'b0;
      end
    join

    while (exp_q.size() != 0 || rd_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0 && rd_q.size() == 0, "R4 all expected traffic seen",
          43'(exp_q.size()), '0);
    finish_run();
  end

endmodule